// File: doc/BRIEF.md
# Register-Programmed SPI Command Engine

This block is an SPI master that runs one short flash-style command at a time. The host programs it through eight byte-wide registers. It loads an opcode, up to three address bytes and an optional trailing data byte. It then writes a control byte that starts the command. The control byte holds three things: a two-bit output-length code, a two-bit input byte count, and a start key in the upper nibble.

The engine keeps chip select low for the whole command. It shifts out 1, 2, 4 or 5 bytes MSB first in SPI mode 0, then clocks in 0 to 3 response bytes. It deposits those bytes into the read registers. Bit 7 of the control register shows that the engine is busy, so software polls it until it clears and then reads the results.

The address registers are laid out in the reverse of wire order. The last register is shared: it supplies the trailing output byte and also receives the third input byte.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every register reads 0x00, chip select is high (inactive) and SCK is low.
- R2: A write to offset 0 whose bits 7:4 equal 0x5 starts a command when idle. Bit 7 of offset 0 reads 1 from the next cycle until the command has fully ended.
- R3: Control bits 1:0 select the number of output bytes: code 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 5. The command issues exactly 8 × (output bytes + input bytes) SCK pulses.
- R4: Wire byte 0 is the opcode at offset 1. For 4- and 5-byte commands, wire bytes 1, 2 and 3 come from offsets 4, 3 and 2. For 2- and 5-byte commands, the last output byte comes from offset 7.
- R5: Control bits 3:2 give the input byte count, 0 to 3. The k-th received byte is stored at offset 5+k. Offsets not reached keep their previous value, so offset 7 keeps its written byte when fewer than 3 bytes are read.
- R6: SPI mode 0 with MSB first. SCK idles low, MOSI does not change on a rising SCK edge, and MISO is sampled on the rising edge.
- R7: Chip select is low for the whole command, across both the output and input phases, with no SCK pulse while it is high. It returns high before the busy bit clears.
- R8: While busy, writes to the control register and to offsets 1–4 and 7 are ignored.
- R9: A control write whose upper nibble is not 0x5 does not start a command.
- R10: Bits 3:0 of offset 0 read back the input count and length code of the last accepted command, and bits 6:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for reads and writes |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Every pair of length code and input count is tried, 16 in all, each with several distinct register contents and response patterns. A serial-device model in the bench records each MOSI bit and returns a distinct, computed byte per bus position. This separates a wrong byte order, a wrong length mapping and a read byte landing in the wrong register. The shared offset 7 is checked both when it is overwritten (3 input bytes) and when it must survive (fewer input bytes). Separate runs cover an invalid start key and writes made while a command is in flight.

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine #(
  parameter int HALF_DIV = 2,
  parameter logic [3:0] GO_KEY = 4'h5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_END = DW'(HALF_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TAIL} st_t;

  st_t         st;
  logic [7:0]  op_q, adr2_q, adr3_q, adr4_q, rd5_q, rd6_q, sh7_q;
  logic [1:0]  wcode_q, rcnt_q;
  logic [DW-1:0] div_q;
  logic [7:0]  tx_sr, rx_sr;
  logic [2:0]  bit_q, idx_q;
  logic        sck_q, cs_q;

  logic       busy, tick, go;
  logic [2:0] nout, last_idx, rd_slot;
  logic [7:0] rx_byte;

  assign busy     = (st != S_IDLE);
  assign tick     = (div_q == DIV_END);
  assign go       = wr_en && (addr == 3'd0) && !busy && (wdata[7:4] == GO_KEY);
  assign nout     = (wcode_q == 2'd0) ? 3'd1 : (wcode_q == 2'd1) ? 3'd2 :
                    (wcode_q == 2'd2) ? 3'd4 : 3'd5;
  assign last_idx = nout + {1'b0, rcnt_q} - 3'd1;
  assign rd_slot  = idx_q - nout;
  assign rx_byte  = rx_sr;

  assign spi_sck  = sck_q;
  assign spi_cs_n = cs_q;
  assign spi_mosi = tx_sr[7];

  function automatic logic [7:0] next_tx(input logic [2:0] i);
    if (i >= nout) return 8'h00;
    case (i)
      3'd1:    return (wcode_q == 2'd1) ? sh7_q : adr4_q;
      3'd2:    return adr3_q;
      3'd3:    return adr2_q;
      3'd4:    return sh7_q;
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    case (addr)
      3'd0: rdata = {busy, 3'b000, rcnt_q, wcode_q};
      3'd1: rdata = op_q;
      3'd2: rdata = adr2_q;
      3'd3: rdata = adr3_q;
      3'd4: rdata = adr4_q;
      3'd5: rdata = rd5_q;
      3'd6: rdata = rd6_q;
      default: rdata = sh7_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= '0; adr2_q <= '0; adr3_q <= '0; adr4_q <= '0;
      rd5_q <= '0; rd6_q <= '0; sh7_q <= '0;
      wcode_q <= '0; rcnt_q <= '0;
      div_q <= '0; tx_sr <= '0; rx_sr <= '0;
      bit_q <= '0; idx_q <= '0;
      sck_q <= 1'b0; cs_q <= 1'b1;
    end else begin
      if (wr_en && !busy) begin
        case (addr)
          3'd1: op_q   <= wdata;
          3'd2: adr2_q <= wdata;
          3'd3: adr3_q <= wdata;
          3'd4: adr4_q <= wdata;
          3'd7: sh7_q  <= wdata;
          default: ;
        endcase
      end
      case (st)
        S_IDLE: begin
          div_q <= '0;
          if (go) begin
            wcode_q <= wdata[1:0];
            rcnt_q  <= wdata[3:2];
            tx_sr   <= op_q;
            bit_q   <= '0;
            idx_q   <= '0;
            cs_q    <= 1'b0;
            st      <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          div_q <= tick ? '0 : div_q + 1'b1;
          if (tick) begin
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx_sr <= {rx_sr[6:0], spi_miso};
            end else begin
              sck_q <= 1'b0;
              bit_q <= bit_q + 3'd1;
              if (bit_q == 3'd7) begin
                if (idx_q >= nout) begin
                  case (rd_slot)
                    3'd0:    rd5_q <= rx_byte;
                    3'd1:    rd6_q <= rx_byte;
                    default: sh7_q <= rx_byte;
                  endcase
                end
                if (idx_q == last_idx) begin
                  cs_q  <= 1'b1;
                  tx_sr <= '0;
                  st    <= S_TAIL;
                end else begin
                  idx_q <= idx_q + 3'd1;
                  tx_sr <= next_tx(idx_q + 3'd1);
                end
              end else begin
                tx_sr <= {tx_sr[6:0], 1'b0};
              end
            end
          end
        end
        default: begin
          div_q <= tick ? '0 : div_q + 1'b1;
          if (tick) st <= S_IDLE;
        end
      endcase
    end
  end

  a_r7_cs_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  a_r6_mosi_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi));
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && addr == 3'd0 && wdata[7:4] == GO_KEY) |=> (busy && !spi_cs_n));
  a_r9_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && addr == 3'd0 && wdata[7:4] != GO_KEY) |=> !busy);
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == 3'd1) |=> $stable(op_q));
  a_r7_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> spi_cs_n && $past(spi_cs_n));
endmodule

// File: tb/test_spi_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0, errors = 0;
  int sbit = 0, cs_viol = 0, rseed = 0;
  logic [7:0] cap [8];

  spi_cmd_engine #(.HALF_DIV(2), .GO_KEY(4'h5)) i_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] resp(input int j);
    return 8'(rseed * 37 + j * 11 + 8'h5A);
  endfunction

  always @(negedge spi_cs_n) begin
    logic [7:0] b;
    b = resp(0);
    spi_miso = b[7];
  end
  always @(posedge spi_sck) begin
    if (spi_cs_n) cs_viol++;
    if (sbit < 64) cap[sbit/8][7-(sbit%8)] = spi_mosi;
    sbit++;
  end
  always @(negedge spi_sck) begin
    logic [7:0] b;
    b = resp(sbit / 8);
    spi_miso = b[7-(sbit%8)];
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [7:0] s;
    cyc = 0;
    rd(3'd0, s);
    while (s[7] && cyc < 2000) begin rd(3'd0, s); cyc++; end
    check(!s[7], "R2 busy clears", s, 0);
    check(spi_cs_n == 1'b1, "R7 cs high once busy clear", spi_cs_n, 1);
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp_b [5];
    int cyc, nout;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check(v == 8'h00, "R1 reset register", v, 0);
    end
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 reset pins", {spi_cs_n, spi_sck}, 2);

    for (int s = 0; s < 3; s++)
      for (int wc = 0; wc < 4; wc++)
        for (int rc = 0; rc < 4; rc++) begin
          logic [7:0] v1, v2, v3, v4, v7;
          rseed = s * 16 + wc * 4 + rc;
          v1 = 8'(8'h9F ^ rseed); v2 = 8'(8'h21 + rseed); v3 = 8'(8'h42 + 3 * rseed);
          v4 = 8'(8'h83 ^ (rseed << 2)); v7 = 8'(8'hC4 + 5 * rseed);
          wr(3'd1, v1); wr(3'd2, v2); wr(3'd3, v3); wr(3'd4, v4); wr(3'd7, v7);
          nout = (wc == 0) ? 1 : (wc == 1) ? 2 : (wc == 2) ? 4 : 5;
          exp_b[0] = v1; exp_b[1] = (wc == 1) ? v7 : v4; exp_b[2] = v3; exp_b[3] = v2; exp_b[4] = v7;
          sbit = 0; cs_viol = 0;
          wr(3'd0, {4'h5, 2'(rc), 2'(wc)});
          rd(3'd0, v);
          check(v[7] == 1'b1, "R2 busy after start", v, 8'h80);
          if (s == 1) begin
            wr(3'd0, 8'h5F);
            wr(3'd1, 8'hEE);
          end
          wait_idle(cyc);
          check(sbit == 8 * (nout + rc), "R3 SCK pulse count", sbit, 8 * (nout + rc));
          check(cs_viol == 0, "R7 no SCK with cs high", cs_viol, 0);
          for (int b = 0; b < nout; b++)
            check(cap[b] == exp_b[b], "R4 R6 wire byte", cap[b], exp_b[b]);
          for (int k = 0; k < rc; k++) begin
            rd(3'(5 + k), v);
            check(v == resp(nout + k), "R5 read byte", v, resp(nout + k));
          end
          if (rc < 3) begin
            rd(3'd7, v);
            check(v == v7, "R5 offset 7 kept", v, v7);
          end
          rd(3'd0, v);
          check(v == {4'h0, 2'(rc), 2'(wc)}, "R10 control readback", v, {4'h0, 2'(rc), 2'(wc)});
          if (s == 1) begin
            rd(3'd1, v);
            check(v == v1, "R8 opcode write while busy ignored", v, v1);
          end
        end

    for (int k = 0; k < 16; k++) begin
      if (k == 5) continue;
      sbit = 0;
      wr(3'd0, {4'(k), 4'b0110});
      repeat (10) @(negedge clk);
      rd(3'd0, v);
      check(v[7] == 1'b0 && sbit == 0 && spi_cs_n, "R9 bad key no start", {v[7], 8'(sbit)}, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule